// File: doc/BRIEF.md
# Vector Upper-State Tracking Controller

This block follows the clean or dirty condition of the upper portions of a wide SIMD register file as decoded instruction descriptors are accepted, one per cycle, under a valid/ready handshake. Each descriptor gives an encoding class, an operation width, a destination index, write flags and flags for the special operations: zero-upper, zero-all, save-state and restore-state. The block models only the bookkeeping state and its side effects. It holds no register data and controls no clocks or execution units.

Three flags are kept, and each has its own entry and exit rules. The first is `dirty128`: a 256-bit VEX or EVEX write to registers 0..15 has left upper-128 halves non-zero. The second is `dirty256`: a 512-bit write to registers 0..15 has left upper-256 halves non-zero. The third is `dirty_hi`: a 512-bit write to registers 16..31 has happened. A legacy-encoded vector write that arrives while `dirty128` is set produces a one-cycle penalty pulse and a stall countdown that holds the handshake off. The frequency-license output reports the level required by the last vector operation, and `dirty256` holds that level at a floor of 1. A save request reports whether a compact save is possible.

Top module: `upper_state_tracker`

## Requirements
- R1: After reset all three dirty flags are 0, `license` is 0, `penalty_pulse`, `compact_save` and `stall_cnt` are 0, and `in_ready` is 1.
- R2: An accepted ordinary descriptor with `in_wr_vec`=1, `in_width`=1 (256-bit), `in_enc` of 1 (VEX) or 2 (EVEX) and `in_dst` below 16 sets `dirty128` in the next cycle.
- R3: An accepted ordinary descriptor with `in_enc`=0 (legacy) and `in_wr_vec`=1 while `dirty128` is 1 raises `penalty_pulse` for exactly one cycle after acceptance. In that cycle `stall_cnt` equals STALL_CYCLES (default 24). After that, `stall_cnt` falls by 1 per cycle. `in_ready` is 0 while `stall_cnt` is non-zero, and `dirty128` stays 1.
- R4: No penalty occurs for a legacy write while `dirty128` is 0, and that write changes no dirty flag. No penalty occurs for a VEX or EVEX write of any width, whatever the state.
- R5: An accepted ordinary descriptor with `in_width`=2 (512-bit), `in_wr_vec`=1 and `in_dst` below 16 sets `dirty256`. This includes zeroing idioms, which are ordinary vector writes.
- R6: A 512-bit vector write with `in_dst` of 16..31 sets `dirty_hi` and leaves `dirty256` unchanged. A 512-bit descriptor that writes only a mask (`in_wr_mask`=1, `in_wr_vec`=0) changes no dirty flag.
- R7: After an accepted ordinary descriptor with `in_simd`=1, `license` becomes 2 for width 2, 1 for width 1, and 0 for width 0. If `dirty256` is 1 when a width 0 or width 1 descriptor is accepted, `license` becomes 1. Otherwise `license` holds its value.
- R8: An accepted descriptor with `in_zupper` or `in_zall` set clears `dirty128` and `dirty256` and leaves `dirty_hi` unchanged.
- R9: An accepted descriptor with `in_save` set raises `compact_save` for one cycle if all three dirty flags are 0 at acceptance. Otherwise `compact_save` stays 0.
- R10: An accepted descriptor with `in_restore` set loads `{dirty_hi, dirty256, dirty128}` from `restore_bits[2:0]`. Restore takes priority over save, save over zeroing, and zeroing over an ordinary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor can be accepted (no stall pending) |
| in_enc | input | 2 | Encoding: 0 legacy, 1 VEX, 2 EVEX |
| in_width | input | 2 | Width: 0 = 128, 1 = 256, 2 = 512 bits |
| in_dst | input | REG_IDX_W | Destination register index |
| in_wr_vec | input | 1 | Writes a vector register |
| in_wr_mask | input | 1 | Writes a mask register |
| in_simd | input | 1 | Uses vector or FP execution |
| in_zupper | input | 1 | Zero-upper operation |
| in_zall | input | 1 | Zero-all operation |
| in_save | input | 1 | Save-state request |
| in_restore | input | 1 | Restore-state request |
| restore_bits | input | 3 | Flags to restore: {hi, upper256, upper128} |
| dirty128 | output | 1 | Upper-128 dirty |
| dirty256 | output | 1 | Upper-256 dirty (registers 0..15) |
| dirty_hi | output | 1 | Registers 16..31 wide state dirty |
| penalty_pulse | output | 1 | One-cycle transition-penalty indication |
| stall_cnt | output | CW | Remaining stall cycles |
| license | output | 2 | Frequency-license level |
| compact_save | output | 1 | One-cycle hint: upper halves need not be saved |

## Verification
The hardest state to reach from the ports is `dirty_hi` set while `dirty256` and `dirty128` are clear, because a zeroing operation must not touch the high bank. The stimulus reaches it with a 512-bit write to index 20, then a write to index 0 and a zero-all. The stimulus then shows that a save still refuses the compact hint, and that only a restore clears the flag. The penalty countdown is checked by counting the negedges during which the handshake is held low after a legacy write. Descriptors are sent only after ready returns.

// File: rtl/upper_state_tracker.sv
module upper_state_tracker #(
  parameter int STALL_CYCLES = 24,
  parameter int REG_IDX_W    = 5,
  localparam int CW          = $clog2(STALL_CYCLES + 1),
  localparam int LOW_BANK    = 2 ** (REG_IDX_W - 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_enc,
  input  logic [1:0]           in_width,
  input  logic [REG_IDX_W-1:0] in_dst,
  input  logic                 in_wr_vec,
  input  logic                 in_wr_mask,
  input  logic                 in_simd,
  input  logic                 in_zupper,
  input  logic                 in_zall,
  input  logic                 in_save,
  input  logic                 in_restore,
  input  logic [2:0]           restore_bits,
  output logic                 dirty128,
  output logic                 dirty256,
  output logic                 dirty_hi,
  output logic                 penalty_pulse,
  output logic [CW-1:0]        stall_cnt,
  output logic [1:0]           license,
  output logic                 compact_save
);
  localparam logic [1:0] ENC_LEGACY = 2'd0;
  localparam logic [1:0] W256 = 2'd1;
  localparam logic [1:0] W512 = 2'd2;
  localparam logic [CW-1:0] STALL_LOAD = CW'(STALL_CYCLES);

  logic acc, ordinary, zero_op, save_op, lo_dst;
  logic set128, set256, sethi, pen;
  logic [1:0] lic_next;

  assign in_ready = (stall_cnt == '0);
  assign acc      = in_valid & in_ready;
  assign save_op  = acc & ~in_restore & in_save;
  assign zero_op  = acc & ~in_restore & ~in_save & (in_zupper | in_zall);
  assign ordinary = acc & ~in_restore & ~in_save & ~in_zupper & ~in_zall;
  assign lo_dst   = (int'(in_dst) < LOW_BANK);

  assign set128 = ordinary & in_wr_vec & lo_dst & (in_width == W256) & (in_enc != ENC_LEGACY);
  assign set256 = ordinary & in_wr_vec & lo_dst & (in_width == W512);
  assign sethi  = ordinary & in_wr_vec & ~lo_dst & (in_width == W512);
  assign pen    = ordinary & in_wr_vec & (in_enc == ENC_LEGACY) & dirty128;

  always_comb begin
    case (in_width)
      W512:    lic_next = 2'd2;
      W256:    lic_next = 2'd1;
      default: lic_next = dirty256 ? 2'd1 : 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty128 <= 1'b0;
      dirty256 <= 1'b0;
      dirty_hi <= 1'b0;
    end else if (acc & in_restore) begin
      dirty128 <= restore_bits[0];
      dirty256 <= restore_bits[1];
      dirty_hi <= restore_bits[2];
    end else if (zero_op) begin
      dirty128 <= 1'b0;
      dirty256 <= 1'b0;
    end else begin
      if (set128) dirty128 <= 1'b1;
      if (set256) dirty256 <= 1'b1;
      if (sethi)  dirty_hi <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_cnt     <= '0;
      penalty_pulse <= 1'b0;
      compact_save  <= 1'b0;
      license       <= 2'd0;
    end else begin
      penalty_pulse <= pen;
      compact_save  <= save_op & ~dirty128 & ~dirty256 & ~dirty_hi;
      if (pen)
        stall_cnt <= STALL_LOAD;
      else if (stall_cnt != '0)
        stall_cnt <= stall_cnt - 1'b1;
      if (ordinary & in_simd)
        license <= lic_next;
    end
  end

  logic unused_ok;
  assign unused_ok = in_wr_mask;
endmodule

// File: rtl/upper_state_tracker_chk.sv
module upper_state_tracker_chk #(
  parameter int STALL_CYCLES = 24,
  parameter int REG_IDX_W    = 5,
  localparam int CW          = $clog2(STALL_CYCLES + 1),
  localparam int LOW_BANK    = 2 ** (REG_IDX_W - 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [1:0]           in_enc,
  input logic [1:0]           in_width,
  input logic [REG_IDX_W-1:0] in_dst,
  input logic                 in_wr_vec,
  input logic                 in_simd,
  input logic                 in_save,
  input logic                 in_restore,
  input logic                 dirty128,
  input logic                 dirty256,
  input logic                 dirty_hi,
  input logic                 penalty_pulse,
  input logic [CW-1:0]        stall_cnt,
  input logic [1:0]           license,
  input logic                 compact_save
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R3
  penalty_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    penalty_pulse |-> $past(acc && in_enc == 2'd0 && in_wr_vec && dirty128));

  // R3
  stall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    penalty_pulse |-> (stall_cnt == CW'(STALL_CYCLES) && !in_ready && dirty128));

  // R3
  stall_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt != '0) |=> (stall_cnt == $past(stall_cnt) - 1'b1));

  // R6
  hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dirty_hi) |-> $past(acc && (in_restore ||
      (in_width == 2'd2 && in_wr_vec && int'(in_dst) >= LOW_BANK))));

  // R8
  hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dirty_hi) |-> $past(acc && in_restore));

  // R9
  compact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compact_save |-> $past(acc && in_save && !in_restore && !dirty128 && !dirty256 && !dirty_hi));

  // R7
  license_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(license) |-> $past(acc && in_simd));
endmodule

bind upper_state_tracker upper_state_tracker_chk #(
  .STALL_CYCLES(STALL_CYCLES), .REG_IDX_W(REG_IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_enc(in_enc), .in_width(in_width), .in_dst(in_dst), .in_wr_vec(in_wr_vec),
  .in_simd(in_simd), .in_save(in_save), .in_restore(in_restore),
  .dirty128(dirty128), .dirty256(dirty256), .dirty_hi(dirty_hi),
  .penalty_pulse(penalty_pulse), .stall_cnt(stall_cnt), .license(license),
  .compact_save(compact_save)
);

// File: tb/upper_state_tracker_test.sv
module upper_state_tracker_test;
  localparam int STALL = 24;
  localparam int CW = $clog2(STALL + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_enc = '0, in_width = '0;
  logic [4:0] in_dst = '0;
  logic in_wr_vec = 0, in_wr_mask = 0, in_simd = 0, in_zupper = 0, in_zall = 0;
  logic in_save = 0, in_restore = 0;
  logic [2:0] restore_bits = '0;
  logic dirty128, dirty256, dirty_hi, penalty_pulse, compact_save;
  logic [CW-1:0] stall_cnt;
  logic [1:0] license;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  upper_state_tracker #(.STALL_CYCLES(STALL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_enc(in_enc), .in_width(in_width), .in_dst(in_dst), .in_wr_vec(in_wr_vec),
    .in_wr_mask(in_wr_mask), .in_simd(in_simd), .in_zupper(in_zupper),
    .in_zall(in_zall), .in_save(in_save), .in_restore(in_restore),
    .restore_bits(restore_bits), .dirty128(dirty128), .dirty256(dirty256),
    .dirty_hi(dirty_hi), .penalty_pulse(penalty_pulse), .stall_cnt(stall_cnt),
    .license(license), .compact_save(compact_save)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = 0; in_enc = 0; in_width = 0; in_dst = 0; in_wr_vec = 0;
    in_wr_mask = 0; in_simd = 0; in_zupper = 0; in_zall = 0; in_save = 0;
    in_restore = 0; restore_bits = 0;
  endtask

  task automatic send(input logic [1:0] enc, input logic [1:0] w, input int dst,
                      input logic wv, input logic wm, input logic simd);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_enc = enc; in_width = w; in_dst = 5'(dst);
    in_wr_vec = wv; in_wr_mask = wm; in_simd = simd;
    @(negedge clk);
    clear_in();
  endtask

  task automatic special(input logic zu, input logic za, input logic sv,
                         input logic rs, input logic [2:0] bits);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_zupper = zu; in_zall = za; in_save = sv;
    in_restore = rs; restore_bits = bits;
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_reset();
    chk("R1 dirty128", dirty128, 0);
    chk("R1 dirty256", dirty256, 0);
    chk("R1 dirty_hi", dirty_hi, 0);
    chk("R1 license", license, 0);
    chk("R1 pulses", penalty_pulse | compact_save, 0);
    chk("R1 stall", stall_cnt, 0);
    chk("R1 ready", in_ready, 1);
  endtask

  task automatic t_vex256();
    send(2'd1, 2'd1, 3, 1, 0, 1);
    chk("R2 dirty128 set", dirty128, 1);
    chk("R7 license 256", license, 1);
  endtask

  task automatic t_penalty();
    int waited = 0;
    send(2'd0, 2'd0, 5, 1, 0, 1);
    chk("R3 pulse", penalty_pulse, 1);
    chk("R3 stall load", stall_cnt, STALL);
    chk("R3 ready low", in_ready, 0);
    @(negedge clk);
    chk("R3 pulse one cycle", penalty_pulse, 0);
    chk("R3 stall dec", stall_cnt, STALL - 1);
    waited = 1;
    while (!in_ready) begin @(negedge clk); waited++; end
    chk("R3 stall length", waited, STALL);
    chk("R3 dirty128 kept", dirty128, 1);
  endtask

  task automatic t_mix();
    send(2'd2, 2'd0, 4, 1, 0, 1);
    chk("R4 evex no penalty", penalty_pulse, 0);
    chk("R4 evex ready", in_ready, 1);
    chk("R7 license 128", license, 0);
    special(1, 0, 0, 0, 3'b000);
    chk("R8 zupper clears 128", dirty128, 0);
    send(2'd0, 2'd0, 5, 1, 0, 1);
    chk("R4 legacy clean no penalty", penalty_pulse, 0);
    chk("R4 legacy clean state", {dirty_hi, dirty256, dirty128}, 0);
    chk("R4 legacy clean ready", in_ready, 1);
  endtask

  task automatic t_wide();
    send(2'd2, 2'd2, 2, 0, 1, 1);
    chk("R6 mask only", {dirty_hi, dirty256, dirty128}, 0);
    send(2'd2, 2'd2, 20, 1, 0, 1);
    chk("R6 high bank hi", dirty_hi, 1);
    chk("R6 high bank 256", dirty256, 0);
    send(2'd2, 2'd2, 0, 1, 0, 1);
    chk("R5 zero idiom dirty256", dirty256, 1);
    chk("R7 license 512", license, 2);
    send(2'd1, 2'd0, 1, 1, 0, 1);
    chk("R7 license floor", license, 1);
    send(2'd0, 2'd0, 1, 1, 0, 1);
    chk("R4 legacy no 128 dirty", penalty_pulse, 0);
    chk("R7 license floor legacy", license, 1);
  endtask

  task automatic t_save_restore();
    special(0, 0, 1, 0, 3'b000);
    chk("R9 dirty no compact", compact_save, 0);
    special(0, 1, 0, 0, 3'b000);
    chk("R8 zall clears 256", dirty256, 0);
    chk("R8 zall keeps hi", dirty_hi, 1);
    special(0, 0, 1, 0, 3'b000);
    chk("R9 hi dirty no compact", compact_save, 0);
    special(0, 0, 0, 1, 3'b000);
    chk("R10 restore clean", {dirty_hi, dirty256, dirty128}, 0);
    special(0, 0, 1, 0, 3'b000);
    chk("R9 compact", compact_save, 1);
    @(negedge clk);
    chk("R9 compact one cycle", compact_save, 0);
    special(0, 0, 1, 1, 3'b101);
    chk("R10 restore bits", {dirty_hi, dirty256, dirty128}, 3'b101);
    chk("R10 restore beats save", compact_save, 0);
    send(2'd1, 2'd0, 1, 1, 0, 1);
    chk("R7 license after clean", license, 0);
  endtask

  initial begin
    fork
      begin
        clear_in();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_vex256();
        t_penalty();
        t_mix();
        t_wide();
        t_save_restore();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule